// File: doc/BRIEF.md
# Translation Capability Register Unit

The unit holds a small file of translation registers that unprivileged code can use as capabilities for physical memory access. A translate command names a destination register and a virtual address. The unit sends the virtual page to an external page-table responder and waits for its answer. It then stores the physical page, the permission bits, the virtual page and a capability tag in that register. Later load and store commands name a register, a byte offset and an access size. The unit forms the physical address from the stored page, with no TLB lookup, and checks the tag, the page bounds and the permissions first.

A separate OS port can overwrite or invalidate any register, the same way it would manage extra TLB entries. Both kinds of OS write clear the capability tag. Only a completed translate sets the tag. The virtual page stays in the register after an OS write. An access through such a register therefore returns a retranslate request carrying the virtual address, and does not trap. Software can then reissue the translate.

A four-state controller runs the block. ST_IDLE accepts a command. Translate commands go to ST_WALK_REQ, where the page-table request is issued for one cycle. The controller then moves to ST_WALK_WAIT, and returns to ST_IDLE when the response arrives. Load, store and reserved commands go from ST_IDLE to ST_CHECK, which evaluates the access and returns to ST_IDLE in the next cycle. Each completed command produces one result pulse.

Top module: `xlat_cap_unit`

## Requirements
- R1: `cmd_ready` is high only in ST_IDLE. A translate accepted at a clock edge drives `pt_req_valid` for exactly the following cycle, with `pt_req_vpn` equal to the virtual address shifted right by 12. `pt_rsp_valid` is ignored in every state except ST_WALK_WAIT.
- R2: A page-table response without fault writes the physical page, the permissions (bit 0 read, bit 1 write) and the virtual page into the register, and sets its tag. The result pulse follows the same edge, with no trap and `res_paddr` = ppn*4096 + (vaddr mod 4096).
- R3: A page-table response with fault gives trap cause 5 and leaves the register unchanged.
- R4: A permitted load or store returns `res_paddr` = ppn*4096 + offset. The result is valid in the cycle after the edge that follows acceptance.
- R5: An access traps with cause 2 when offset + 2^size exceeds 4096. An access that ends exactly at 4096 is allowed.
- R6: A store (op 2) to a register without write permission traps with cause 3. A load (op 1) without read permission traps with cause 4. The bounds check comes before both permission checks.
- R7: An access through a register that has never held a translation traps with cause 1.
- R8: An OS invalidate (`os_inval`=1) clears the tag and keeps the virtual page. A later access returns `res_retrans`=1 with no trap and `res_vaddr` = vpn*4096 + (offset mod 4096).
- R9: An OS overwrite (`os_inval`=0) writes the physical page, permissions and virtual page, and clears the tag, so a later access asks for retranslation of the new virtual page. When an OS write and a translate fill hit the same register at the same edge, the OS write wins.
- R10: Op code 3 is reserved and traps with cause 6.
- R11: During reset and after it, all registers are untagged and hold no virtual page, `cmd_ready` is 1, and every result output is 0.
- R12: A trapped or retranslate result carries `res_paddr`=0. `res_vaddr` is 0 except on a retranslate result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle and accepting a command |
| cmd_op | input | 2 | 0 translate, 1 load, 2 store, 3 reserved |
| cmd_idx | input | IDX_W | Target translation register |
| cmd_vaddr | input | VA_W | Virtual address for translate |
| cmd_offset | input | OFF_W | Byte offset for load/store |
| cmd_size | input | 2 | Log2 of access bytes |
| pt_req_valid | output | 1 | Page-table request strobe |
| pt_req_vpn | output | VA_W-12 | Virtual page requested |
| pt_rsp_valid | input | 1 | Page-table answer strobe |
| pt_rsp_ppn | input | PA_W-12 | Physical page answered |
| pt_rsp_perm | input | 2 | Permissions answered |
| pt_rsp_fault | input | 1 | Page-table fault |
| os_valid | input | 1 | OS write strobe |
| os_inval | input | 1 | 1 invalidate, 0 overwrite |
| os_idx | input | IDX_W | Register written by the OS |
| os_ppn | input | PA_W-12 | Physical page for overwrite |
| os_perm | input | 2 | Permissions for overwrite |
| os_vpn | input | VA_W-12 | Virtual page for overwrite |
| res_valid | output | 1 | Result pulse |
| res_trap | output | 1 | Command trapped |
| res_cause | output | 3 | Trap cause code |
| res_retrans | output | 1 | Retranslate request |
| res_paddr | output | PA_W | Physical address result |
| res_vaddr | output | VA_W | Virtual address to retranslate |

## Verification
A load, store or reserved command accepted at edge N has its result registered at edge N+1. A translate accepted at edge N raises its request from N to N+1 and completes at the first edge from N+2 onward where a response is present. Register contents change at that same completion edge, and an OS write changes them at the edge where it is sampled. The bench model advances on the same rising edges, using only the sampled inputs. Its expected outputs are compared at every falling edge, so each result is checked in the one cycle it is due and must be absent in every other cycle.

// File: rtl/xcu_pkg.sv
package xcu_pkg;

    typedef enum logic [1:0] {
        OP_XLATE = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STORE = 2'd2,
        OP_RSVD  = 2'd3
    } xcu_op_e;

    typedef enum logic [2:0] {
        CZ_NONE    = 3'd0,
        CZ_NOTAG   = 3'd1,
        CZ_BOUNDS  = 3'd2,
        CZ_WDENY   = 3'd3,
        CZ_RDENY   = 3'd4,
        CZ_WALKFLT = 3'd5,
        CZ_BADOP   = 3'd6
    } xcu_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_WALK_REQ  = 2'd1,
        ST_WALK_WAIT = 2'd2,
        ST_CHECK     = 2'd3
    } xcu_state_e;

    localparam int PERM_RD = 0;
    localparam int PERM_WR = 1;

endpackage

// File: rtl/xcu_regfile.sv
module xcu_regfile #(
    parameter int NREG  = 4,
    parameter int PPN_W = 20,
    parameter int VPN_W = 20,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [1:0]       fill_perm,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic             os_valid,
    input  logic             os_inval,
    input  logic [IDX_W-1:0] os_idx,
    input  logic [PPN_W-1:0] os_ppn,
    input  logic [1:0]       os_perm,
    input  logic [VPN_W-1:0] os_vpn,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_tag,
    output logic             rd_held,
    output logic [1:0]       rd_perm,
    output logic [PPN_W-1:0] rd_ppn,
    output logic [VPN_W-1:0] rd_vpn
);

    logic [NREG-1:0]            tag_vec;
    logic [NREG-1:0]            held_vec;
    logic [NREG-1:0][1:0]       perm_vec;
    logic [NREG-1:0][PPN_W-1:0] ppn_vec;
    logic [NREG-1:0][VPN_W-1:0] vpn_vec;

    for (genvar i = 0; i < NREG; i++) begin : g_ent
        logic             tag_q;
        logic             held_q;
        logic [1:0]       perm_q;
        logic [PPN_W-1:0] ppn_q;
        logic [VPN_W-1:0] vpn_q;
        logic             os_hit;
        logic             fill_hit;

        assign os_hit   = os_valid && (os_idx == IDX_W'(i));
        assign fill_hit = fill_en && (fill_idx == IDX_W'(i));

        // OS writes take precedence over a same-edge fill; both leave tag rules intact
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q  <= 1'b0;
                held_q <= 1'b0;
                perm_q <= '0;
                ppn_q  <= '0;
                vpn_q  <= '0;
            end else if (os_hit) begin
                tag_q <= 1'b0;
                if (!os_inval) begin
                    held_q <= 1'b1;
                    perm_q <= os_perm;
                    ppn_q  <= os_ppn;
                    vpn_q  <= os_vpn;
                end
            end else if (fill_hit) begin
                tag_q  <= 1'b1;
                held_q <= 1'b1;
                perm_q <= fill_perm;
                ppn_q  <= fill_ppn;
                vpn_q  <= fill_vpn;
            end
        end

        assign tag_vec[i]  = tag_q;
        assign held_vec[i] = held_q;
        assign perm_vec[i] = perm_q;
        assign ppn_vec[i]  = ppn_q;
        assign vpn_vec[i]  = vpn_q;
    end

    assign rd_tag  = tag_vec[rd_idx];
    assign rd_held = held_vec[rd_idx];
    assign rd_perm = perm_vec[rd_idx];
    assign rd_ppn  = ppn_vec[rd_idx];
    assign rd_vpn  = vpn_vec[rd_idx];

endmodule

// File: rtl/xcu_access_check.sv
module xcu_access_check
    import xcu_pkg::*;
#(
    parameter int PG_BITS = 12,
    parameter int PPN_W   = 20,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 16,
    parameter int PA_W    = PPN_W + PG_BITS,
    parameter int VA_W    = VPN_W + PG_BITS
) (
    input  xcu_op_e          op,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    input  logic             tag,
    input  logic             held,
    input  logic [1:0]       perm,
    input  logic [PPN_W-1:0] ppn,
    input  logic [VPN_W-1:0] vpn,
    output logic             trap,
    output xcu_cause_e       cause,
    output logic             retrans,
    output logic [PA_W-1:0]  paddr,
    output logic [VA_W-1:0]  vaddr
);

    localparam int END_W      = OFF_W + 1;
    localparam int PAGE_BYTES = 1 << PG_BITS;

    logic [END_W-1:0] end_byte;
    logic             out_of_page;

    assign end_byte    = {1'b0, offset} + (END_W'(1) << size);
    assign out_of_page = end_byte > END_W'(PAGE_BYTES);

    always_comb begin
        trap    = 1'b0;
        cause   = CZ_NONE;
        retrans = 1'b0;
        paddr   = '0;
        vaddr   = '0;
        if (op == OP_RSVD || op == OP_XLATE) begin
            trap  = 1'b1;
            cause = CZ_BADOP;
        end else if (!tag && held) begin
            retrans = 1'b1;
            vaddr   = VA_W'({vpn, offset[PG_BITS-1:0]});
        end else if (!tag) begin
            trap  = 1'b1;
            cause = CZ_NOTAG;
        end else if (out_of_page) begin
            trap  = 1'b1;
            cause = CZ_BOUNDS;
        end else if (op == OP_STORE && !perm[PERM_WR]) begin
            trap  = 1'b1;
            cause = CZ_WDENY;
        end else if (op == OP_LOAD && !perm[PERM_RD]) begin
            trap  = 1'b1;
            cause = CZ_RDENY;
        end else begin
            paddr = (PA_W'(ppn) << PG_BITS) + PA_W'(offset);
        end
    end

endmodule

// File: rtl/xcu_fsm.sv
module xcu_fsm
    import xcu_pkg::*;
#(
    parameter int IDX_W   = 2,
    parameter int PG_BITS = 12,
    parameter int PPN_W   = 20,
    parameter int VPN_W   = 20,
    parameter int OFF_W   = 16,
    parameter int PA_W    = PPN_W + PG_BITS,
    parameter int VA_W    = VPN_W + PG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [VA_W-1:0]  cmd_vaddr,
    input  logic [OFF_W-1:0] cmd_offset,
    input  logic [1:0]       cmd_size,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    input  logic             pt_rsp_valid,
    input  logic [PPN_W-1:0] pt_rsp_ppn,
    input  logic [1:0]       pt_rsp_perm,
    input  logic             pt_rsp_fault,
    output logic             fill_en,
    output logic [PPN_W-1:0] fill_ppn,
    output logic [1:0]       fill_perm,
    output logic [VPN_W-1:0] fill_vpn,
    output xcu_op_e          cur_op,
    output logic [IDX_W-1:0] cur_idx,
    output logic [OFF_W-1:0] cur_offset,
    output logic [1:0]       cur_size,
    input  logic             chk_trap,
    input  xcu_cause_e       chk_cause,
    input  logic             chk_retrans,
    input  logic [PA_W-1:0]  chk_paddr,
    input  logic [VA_W-1:0]  chk_vaddr,
    output logic             res_valid,
    output logic             res_trap,
    output xcu_cause_e       res_cause,
    output logic             res_retrans,
    output logic [PA_W-1:0]  res_paddr,
    output logic [VA_W-1:0]  res_vaddr
);

    xcu_state_e st, nxt;

    logic [VA_W-1:0] cur_vaddr;

    logic            rv_d, rt_d, rr_d;
    xcu_cause_e      rc_d;
    logic [PA_W-1:0] rp_d;
    logic [VA_W-1:0] rva_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // transitions and outputs
    always_comb begin
        nxt          = st;
        cmd_ready    = 1'b0;
        pt_req_valid = 1'b0;
        fill_en      = 1'b0;
        rv_d         = 1'b0;
        rt_d         = 1'b0;
        rc_d         = CZ_NONE;
        rr_d         = 1'b0;
        rp_d         = '0;
        rva_d        = '0;
        unique case (st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid)
                    nxt = (xcu_op_e'(cmd_op) == OP_XLATE) ? ST_WALK_REQ : ST_CHECK;
            end
            ST_WALK_REQ: begin
                pt_req_valid = 1'b1;
                nxt          = ST_WALK_WAIT;
            end
            ST_WALK_WAIT: begin
                if (pt_rsp_valid) begin
                    nxt  = ST_IDLE;
                    rv_d = 1'b1;
                    if (pt_rsp_fault) begin
                        rt_d = 1'b1;
                        rc_d = CZ_WALKFLT;
                    end else begin
                        fill_en = 1'b1;
                        rp_d    = PA_W'({pt_rsp_ppn, cur_vaddr[PG_BITS-1:0]});
                    end
                end
            end
            ST_CHECK: begin
                nxt   = ST_IDLE;
                rv_d  = 1'b1;
                rt_d  = chk_trap;
                rc_d  = chk_cause;
                rr_d  = chk_retrans;
                rp_d  = chk_paddr;
                rva_d = chk_vaddr;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // command capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op     <= OP_LOAD;
            cur_idx    <= '0;
            cur_vaddr  <= '0;
            cur_offset <= '0;
            cur_size   <= '0;
        end else if (st == ST_IDLE && cmd_valid) begin
            cur_op     <= xcu_op_e'(cmd_op);
            cur_idx    <= cmd_idx;
            cur_vaddr  <= cmd_vaddr;
            cur_offset <= cmd_offset;
            cur_size   <= cmd_size;
        end
    end

    // result register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid   <= 1'b0;
            res_trap    <= 1'b0;
            res_cause   <= CZ_NONE;
            res_retrans <= 1'b0;
            res_paddr   <= '0;
            res_vaddr   <= '0;
        end else begin
            res_valid   <= rv_d;
            res_trap    <= rt_d;
            res_cause   <= rc_d;
            res_retrans <= rr_d;
            res_paddr   <= rp_d;
            res_vaddr   <= rva_d;
        end
    end

    assign pt_req_vpn = cur_vaddr[VA_W-1:PG_BITS];
    assign fill_ppn   = pt_rsp_ppn;
    assign fill_perm  = pt_rsp_perm;
    assign fill_vpn   = cur_vaddr[VA_W-1:PG_BITS];

endmodule

// File: rtl/xlat_cap_unit.sv
module xlat_cap_unit
    import xcu_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int PG_BITS = 12,
    parameter int OFF_W   = 16,
    localparam int IDX_W  = $clog2(NREG),
    localparam int VPN_W  = VA_W - PG_BITS,
    localparam int PPN_W  = PA_W - PG_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [VA_W-1:0]  cmd_vaddr,
    input  logic [OFF_W-1:0] cmd_offset,
    input  logic [1:0]       cmd_size,
    output logic             pt_req_valid,
    output logic [VPN_W-1:0] pt_req_vpn,
    input  logic             pt_rsp_valid,
    input  logic [PPN_W-1:0] pt_rsp_ppn,
    input  logic [1:0]       pt_rsp_perm,
    input  logic             pt_rsp_fault,
    input  logic             os_valid,
    input  logic             os_inval,
    input  logic [IDX_W-1:0] os_idx,
    input  logic [PPN_W-1:0] os_ppn,
    input  logic [1:0]       os_perm,
    input  logic [VPN_W-1:0] os_vpn,
    output logic             res_valid,
    output logic             res_trap,
    output logic [2:0]       res_cause,
    output logic             res_retrans,
    output logic [PA_W-1:0]  res_paddr,
    output logic [VA_W-1:0]  res_vaddr
);

    logic             fill_en;
    logic [PPN_W-1:0] fill_ppn;
    logic [1:0]       fill_perm;
    logic [VPN_W-1:0] fill_vpn;
    xcu_op_e          cur_op;
    logic [IDX_W-1:0] cur_idx;
    logic [OFF_W-1:0] cur_offset;
    logic [1:0]       cur_size;

    logic             rd_tag, rd_held;
    logic [1:0]       rd_perm;
    logic [PPN_W-1:0] rd_ppn;
    logic [VPN_W-1:0] rd_vpn;

    logic             chk_trap, chk_retrans;
    xcu_cause_e       chk_cause;
    logic [PA_W-1:0]  chk_paddr;
    logic [VA_W-1:0]  chk_vaddr;
    xcu_cause_e       res_cause_e;

    xcu_fsm #(
        .IDX_W(IDX_W), .PG_BITS(PG_BITS), .PPN_W(PPN_W), .VPN_W(VPN_W),
        .OFF_W(OFF_W), .PA_W(PA_W), .VA_W(VA_W)
    ) u_fsm (
        .clk, .rst_n,
        .cmd_valid, .cmd_ready, .cmd_op, .cmd_idx, .cmd_vaddr, .cmd_offset, .cmd_size,
        .pt_req_valid, .pt_req_vpn, .pt_rsp_valid, .pt_rsp_ppn, .pt_rsp_perm, .pt_rsp_fault,
        .fill_en, .fill_ppn, .fill_perm, .fill_vpn,
        .cur_op, .cur_idx, .cur_offset, .cur_size,
        .chk_trap, .chk_cause, .chk_retrans, .chk_paddr, .chk_vaddr,
        .res_valid, .res_trap, .res_cause(res_cause_e), .res_retrans, .res_paddr, .res_vaddr
    );

    xcu_regfile #(
        .NREG(NREG), .PPN_W(PPN_W), .VPN_W(VPN_W), .IDX_W(IDX_W)
    ) u_rf (
        .clk, .rst_n,
        .fill_en, .fill_idx(cur_idx), .fill_ppn, .fill_perm, .fill_vpn,
        .os_valid, .os_inval, .os_idx, .os_ppn, .os_perm, .os_vpn,
        .rd_idx(cur_idx), .rd_tag, .rd_held, .rd_perm, .rd_ppn, .rd_vpn
    );

    xcu_access_check #(
        .PG_BITS(PG_BITS), .PPN_W(PPN_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
        .PA_W(PA_W), .VA_W(VA_W)
    ) u_chk (
        .op(cur_op), .offset(cur_offset), .size(cur_size),
        .tag(rd_tag), .held(rd_held), .perm(rd_perm), .ppn(rd_ppn), .vpn(rd_vpn),
        .trap(chk_trap), .cause(chk_cause), .retrans(chk_retrans),
        .paddr(chk_paddr), .vaddr(chk_vaddr)
    );

    assign res_cause = res_cause_e;

endmodule

// File: rtl/xcu_checker.sv
module xcu_checker #(
    parameter int PA_W = 32,
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_ready,
    input logic            pt_req_valid,
    input logic            res_valid,
    input logic            res_trap,
    input logic [2:0]      res_cause,
    input logic            res_retrans,
    input logic [PA_W-1:0] res_paddr,
    input logic [VA_W-1:0] res_vaddr
);

    p_req_one_cycle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |=> !pt_req_valid);

    p_req_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pt_req_valid |-> !cmd_ready);

    p_res_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !$past(cmd_ready));

    p_trap_coded_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_trap) |-> (res_cause != 3'd0 && res_paddr == '0));

    p_retrans_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_retrans |-> (res_valid && !res_trap && res_cause == 3'd0 && res_paddr == '0));

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_trap && !res_retrans && res_vaddr == '0 && res_paddr == '0));

    p_vaddr_retrans_only_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_retrans) |-> (res_vaddr == '0));

endmodule

bind xlat_cap_unit xcu_checker #(.PA_W(PA_W), .VA_W(VA_W)) u_xcu_checker (
    .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .pt_req_valid(pt_req_valid),
    .res_valid(res_valid), .res_trap(res_trap), .res_cause(res_cause),
    .res_retrans(res_retrans), .res_paddr(res_paddr), .res_vaddr(res_vaddr)
);

// File: tb/sim_xlat_cap_unit.sv
module sim_xlat_cap_unit;

    localparam int CLK_PERIOD = 10;
    localparam int NR   = 4;
    localparam int VAW  = 32;
    localparam int PAW  = 32;
    localparam int PG   = 12;
    localparam int OFW  = 16;
    localparam int IXW  = 2;
    localparam int VPW  = VAW - PG;
    localparam int PPW  = PAW - PG;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic           cmd_valid = 0;
    logic           cmd_ready;
    logic [1:0]     cmd_op = 0;
    logic [IXW-1:0] cmd_idx = 0;
    logic [VAW-1:0] cmd_vaddr = 0;
    logic [OFW-1:0] cmd_offset = 0;
    logic [1:0]     cmd_size = 0;
    logic           pt_req_valid;
    logic [VPW-1:0] pt_req_vpn;
    logic           pt_rsp_valid = 0;
    logic [PPW-1:0] pt_rsp_ppn = 0;
    logic [1:0]     pt_rsp_perm = 0;
    logic           pt_rsp_fault = 0;
    logic           os_valid = 0;
    logic           os_inval = 0;
    logic [IXW-1:0] os_idx = 0;
    logic [PPW-1:0] os_ppn = 0;
    logic [1:0]     os_perm = 0;
    logic [VPW-1:0] os_vpn = 0;
    logic           res_valid;
    logic           res_trap;
    logic [2:0]     res_cause;
    logic           res_retrans;
    logic [PAW-1:0] res_paddr;
    logic [VAW-1:0] res_vaddr;

    xlat_cap_unit u0 (
        .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_op, .cmd_idx, .cmd_vaddr,
        .cmd_offset, .cmd_size, .pt_req_valid, .pt_req_vpn, .pt_rsp_valid,
        .pt_rsp_ppn, .pt_rsp_perm, .pt_rsp_fault, .os_valid, .os_inval, .os_idx,
        .os_ppn, .os_perm, .os_vpn, .res_valid, .res_trap, .res_cause,
        .res_retrans, .res_paddr, .res_vaddr
    );

    int n_chk = 0;
    int n_fail = 0;

    // ---------------- behavioural reference model ----------------
    int      m_st;
    bit      m_tag [NR];
    bit      m_held[NR];
    int      m_perm[NR];
    longint  m_ppn [NR];
    longint  m_vpn [NR];
    int      l_op, l_idx, l_size;
    longint  l_va, l_off;
    bit      e_valid, e_trap, e_retr;
    int      e_cause;
    longint  e_pa, e_va;
    string   e_tag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; e_valid = 0; e_trap = 0; e_retr = 0; e_cause = 0;
            e_pa = 0; e_va = 0; e_tag = "R11";
            l_op = 0; l_idx = 0; l_size = 0; l_va = 0; l_off = 0;
            for (int i = 0; i < NR; i++) begin
                m_tag[i] = 0; m_held[i] = 0; m_perm[i] = 0; m_ppn[i] = 0; m_vpn[i] = 0;
            end
        end else begin
            bit     do_fill;
            longint f_ppn;
            int     f_perm;
            do_fill = 0; f_ppn = 0; f_perm = 0;
            e_valid = 0; e_trap = 0; e_retr = 0; e_cause = 0; e_pa = 0; e_va = 0;
            case (m_st)
                0: if (cmd_valid) begin
                    l_op = int'(cmd_op); l_idx = int'(cmd_idx); l_va = longint'(cmd_vaddr);
                    l_off = longint'(cmd_offset); l_size = int'(cmd_size);
                    m_st = (l_op == 0) ? 1 : 3;
                end
                1: m_st = 2;
                2: if (pt_rsp_valid) begin
                    m_st = 0; e_valid = 1;
                    if (pt_rsp_fault) begin
                        e_trap = 1; e_cause = 5; e_tag = "R3";
                    end else begin
                        do_fill = 1; f_ppn = longint'(pt_rsp_ppn); f_perm = int'(pt_rsp_perm);
                        e_pa = (f_ppn << PG) | (l_va & 'hFFF); e_tag = "R2";
                    end
                end
                default: begin
                    m_st = 0; e_valid = 1;
                    if (l_op == 3) begin
                        e_trap = 1; e_cause = 6; e_tag = "R10";
                    end else if (!m_tag[l_idx] && m_held[l_idx]) begin
                        e_retr = 1; e_va = (m_vpn[l_idx] << PG) | (l_off & 'hFFF); e_tag = "R8 R9";
                    end else if (!m_tag[l_idx]) begin
                        e_trap = 1; e_cause = 1; e_tag = "R7";
                    end else if (l_off + (1 << l_size) > 4096) begin
                        e_trap = 1; e_cause = 2; e_tag = "R5";
                    end else if (l_op == 2 && (m_perm[l_idx] & 2) == 0) begin
                        e_trap = 1; e_cause = 3; e_tag = "R6";
                    end else if (l_op == 1 && (m_perm[l_idx] & 1) == 0) begin
                        e_trap = 1; e_cause = 4; e_tag = "R6";
                    end else begin
                        e_pa = (m_ppn[l_idx] << PG) + l_off; e_tag = "R4";
                    end
                end
            endcase
            if (do_fill) begin
                m_tag[l_idx] = 1; m_held[l_idx] = 1; m_ppn[l_idx] = f_ppn;
                m_perm[l_idx] = f_perm; m_vpn[l_idx] = l_va >> PG;
            end
            if (os_valid) begin
                m_tag[os_idx] = 0;
                if (!os_inval) begin
                    m_held[os_idx] = 1; m_ppn[os_idx] = longint'(os_ppn);
                    m_perm[os_idx] = int'(os_perm); m_vpn[os_idx] = longint'(os_vpn);
                end
            end
        end
    end

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            string ptag;
            cmp("R1", "cmd_ready", longint'(cmd_ready), (m_st == 0) ? 1 : 0);
            cmp("R1", "pt_req_valid", longint'(pt_req_valid), (m_st == 1) ? 1 : 0);
            if (m_st == 1) cmp("R1", "pt_req_vpn", longint'(pt_req_vpn), l_va >> PG);
            cmp(e_valid ? e_tag : "R1", "res_valid", longint'(res_valid), longint'(e_valid));
            cmp(e_valid ? e_tag : "R11", "res_trap", longint'(res_trap), longint'(e_trap));
            cmp(e_valid ? e_tag : "R11", "res_cause", longint'(res_cause), longint'(e_cause));
            cmp(e_valid ? e_tag : "R11", "res_retrans", longint'(res_retrans), longint'(e_retr));
            ptag = (e_trap || e_retr) ? "R12" : (e_valid ? e_tag : "R11");
            cmp(ptag, "res_paddr", longint'(res_paddr), e_pa);
            cmp(e_retr ? e_tag : "R12", "res_vaddr", longint'(res_vaddr), e_va);
        end
    end

    // ---------------- page-table responder ----------------
    int  rsp_lat = 2;
    bit  rsp_fault_sel = 0;
    int  rsp_perm_sel = 3;
    bit  collide = 0;

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && pt_req_valid) begin
                logic [VPW-1:0] v;
                v = pt_req_vpn;
                repeat (rsp_lat) @(negedge clk);
                pt_rsp_valid = 1;
                pt_rsp_ppn   = v ^ 20'hA5A5A;
                pt_rsp_perm  = 2'(rsp_perm_sel);
                pt_rsp_fault = rsp_fault_sel;
                if (collide) begin
                    os_valid = 1; os_inval = 0; os_idx = 2;
                    os_ppn = 20'h0BEEF; os_perm = 2'd3; os_vpn = 20'h00777;
                end
                @(negedge clk);
                pt_rsp_valid = 0; pt_rsp_fault = 0;
                if (collide) os_valid = 0;
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input int op, input int idx, input longint va, input longint off, input int sz);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_op = 2'(op); cmd_idx = IXW'(idx);
        cmd_vaddr = VAW'(va); cmd_offset = OFW'(off); cmd_size = 2'(sz);
        @(negedge clk);
        cmd_valid = 0;
        while (!cmd_ready) @(negedge clk);
    endtask

    task automatic os_write(input bit inval, input int idx, input longint ppn, input int perm, input longint vpn);
        @(negedge clk);
        os_valid = 1; os_inval = inval; os_idx = IXW'(idx);
        os_ppn = PPW'(ppn); os_perm = 2'(perm); os_vpn = VPW'(vpn);
        @(negedge clk);
        os_valid = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs while reset is held
        cmp("R11", "reset cmd_ready", longint'(cmd_ready), 1);
        cmp("R11", "reset res_valid", longint'(res_valid), 0);
        cmp("R11", "reset pt_req_valid", longint'(pt_req_valid), 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        issue(1, 0, 0, 'h10, 2);            // R7: never-translated register
        issue(0, 0, 'h12345678, 0, 0);      // R2: translate, read+write
        issue(1, 0, 0, 'h10, 2);            // R4
        issue(2, 0, 0, 'hFF8, 3);           // R5: ends exactly at page end
        issue(1, 0, 0, 'hFFC, 3);           // R5: crosses page end
        issue(1, 0, 0, 'h1000, 0);          // R5: offset past page
        rsp_perm_sel = 1; rsp_lat = 4;
        issue(0, 1, 'hCAFE0123, 0, 0);      // R2: read-only, slower response
        issue(2, 1, 0, 'h20, 1);            // R6: store denied
        issue(1, 1, 0, 'h20, 1);            // R4: load allowed
        issue(2, 1, 0, 'hFFF, 2);           // R6: bounds ahead of permission
        rsp_perm_sel = 2; rsp_lat = 1;
        issue(0, 2, 'h0000A000, 0, 0);
        issue(1, 2, 0, 4, 0);               // R6: load denied
        @(negedge clk); pt_rsp_valid = 1; pt_rsp_fault = 1;   // R1: stray response while idle
        @(negedge clk); pt_rsp_valid = 0; pt_rsp_fault = 0;
        rsp_fault_sel = 1;
        issue(0, 3, 'h77777000, 0, 0);      // R3: walk fault
        rsp_fault_sel = 0;
        issue(1, 3, 0, 0, 0);               // R3: register still untagged
        os_write(1, 0, 0, 0, 0);            // R8: invalidate
        issue(1, 0, 0, 'h234, 2);           // R8: retranslate request
        rsp_perm_sel = 3;
        issue(0, 0, 'h12345000, 0, 0);      // R8: redo translation
        issue(2, 0, 0, 'h40, 3);
        os_write(0, 1, 'h54321, 3, 'h00ABC); // R9: overwrite
        issue(1, 1, 0, 'h8, 0);             // R9: retranslate of new page
        collide = 1;
        issue(0, 2, 'h00055000, 0, 0);      // R9: OS write wins over fill
        collide = 0;
        issue(1, 2, 0, 'h4, 0);
        issue(3, 0, 0, 0, 0);               // R10
        issue(1, 3, 0, 0, 0);
        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule